// File: doc/BRIEF.md
# Strided Gap Copy DMA Engine

This block copies raw data from one memory region to another in 16-byte chunks, and each side has its own line layout. The source is read as lines of a programmed number of chunks. After each source line, a programmed number of chunks is skipped. The destination is written with its own line length and its own skip. The two walks run independently of each other, so a source line can end in the middle of a destination line. This lets the engine move a sub-rectangle between buffers of different pitches. No data is changed on the way through.

The two base addresses are given as the byte address divided by eight. The total size is a byte count that includes only the chunks actually moved; skipped chunks are not part of it. A start pulse launches a transfer. Completion sets a done bit and gives a one-cycle interrupt. Read requests go out on a request/grant port, and the data comes back in order on a separate valid strobe. Writes go out on a request/grant port. A two-entry chunk buffer sits between reads and writes, so a stalled write side throttles reading.

Top module: `sgc_dma`

## Requirements
- R1: The first read goes to byte address src_base_i*8 and the first write goes to byte address dst_base_i*8.
- R2: With source line width Ws (src_geom_i[15:0], in chunks) and source gap Gs (src_geom_i[31:16], in chunks), read k (counting from 0) addresses byte src_base_i*8 + 16*((k/Ws)*(Ws+Gs) + k%Ws).
- R3: The destination follows the same formula with dst_geom_i, independently of the source line position.
- R4: A transfer performs exactly size_i/16 reads and size_i/16 writes, and write k carries the data returned by read k.
- R5: A start pulse while idle sets ctrl_o bit 0 (busy) and clears bits 8 (done) and 9 (error) on the next cycle. After the last write is accepted, bit 0 is 0 and bit 8 is 1.
- R6: irq_o is high for exactly one cycle per finished transfer, in the cycle in which bit 8 first reads 1.
- R7: A start with a source or destination width of zero, a size of zero, or a size with bits 3:0 not all zero ends the transfer at once. On the next cycle ctrl_o reads 0x300 (done and error), and no read or write is issued.
- R8: At no time have more than 2 chunks been granted for reading but not yet accepted for writing. While writes are refused, reading stops after 2 chunks.
- R9: A start pulse while busy is ignored, and so are the size and geometry presented with it.
- R10: After reset, ctrl_o is 0, irq_o is 0 and no read or write is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_base_i | input | AW-3 | Source byte address divided by 8 |
| dst_base_i | input | AW-3 | Destination byte address divided by 8 |
| size_i | input | AW | Bytes to move, gaps excluded |
| src_geom_i | input | 2*LW | Source line width [15:0] and gap [31:16], in chunks |
| dst_geom_i | input | 2*LW | Destination line width [15:0] and gap [31:16], in chunks |
| start_i | input | 1 | Control write that sets bit 0 (start) |
| ctrl_o | output | 32 | Bit 0 busy, bit 8 done, bit 9 error |
| irq_o | output | 1 | One-cycle done interrupt |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read byte address |
| rd_gnt_i | input | 1 | Read request accepted |
| rd_valid_i | input | 1 | Read data returned, in request order |
| rd_data_i | input | DW | Returned chunk |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | DW | Chunk to write |
| wr_gnt_i | input | 1 | Write request accepted |

## Verification
A line position counter that is off on either side shows up at the affected port as a wrong address, at the first chunk after the faulty line end. That is within one line width of the fault. A wrong remaining count shows up when the transfer finishes: the read or write totals are off, or the done bit is set early or never. A credit error between the buffer and the read side shows up while writes are held back, as more than two outstanding reads, or as data at a write that belongs to a different read index.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int CHUNK_SHIFT  = 4;
  localparam int CTRL_W       = 32;
  localparam int CTRL_BUSY    = 0;
  localparam int CTRL_DONE    = 8;
  localparam int CTRL_ERR     = 9;
  localparam int BUF_DEPTH    = 2;

  typedef struct packed {
    logic busy;
    logic done;
    logic err;
  } sgc_status_t;

  function automatic logic [CTRL_W-1:0] pack_ctrl(input sgc_status_t s);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[CTRL_BUSY] = s.busy;
    w[CTRL_DONE] = s.done;
    w[CTRL_ERR]  = s.err;
    return w;
  endfunction
endpackage

// File: rtl/sgc_walk.sv
module sgc_walk #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          active_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] width_i,
  input  logic [LW-1:0] gap_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          eol_o
);
  logic [AW-1:0] addr_q;
  logic [LW-1:0] col_q, width_q, gap_q;

  function automatic logic [AW-1:0] line_jump(input logic [LW-1:0] gap);
    logic [AW-1:0] g;
    g = AW'(gap);
    return (g + AW'(1)) << CS;
  endfunction

  assign eol_o  = (col_q == width_q - LW'(1));
  assign addr_o = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      col_q   <= '0;
      width_q <= '0;
      gap_q   <= '0;
    end else if (load_i) begin
      addr_q  <= base_i;
      col_q   <= '0;
      width_q <= width_i;
      gap_q   <= gap_i;
    end else if (step_i) begin
      if (eol_o) begin
        col_q  <= '0;
        addr_q <= addr_q + line_jump(gap_q);
      end else begin
        col_q  <= col_q + LW'(1);
        addr_q <= addr_q + (AW'(1) << CS);
      end
    end
  end

  assert_col_in_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && width_q != '0) |-> (col_q < width_q));
endmodule

// File: rtl/sgc_buf2.sv
module sgc_buf2 #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_o,
  output logic [1:0]    count_o
);
  logic [DW-1:0] mem_q [2];
  logic          wp_q, rp_q;
  logic [1:0]    cnt_q;

  assign dout_o  = mem_q[rp_q];
  assign empty_o = (cnt_q == 2'd0);
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q     <= 1'b0;
      rp_q     <= 1'b0;
      cnt_q    <= 2'd0;
      mem_q[0] <= '0;
      mem_q[1] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wp_q] <= din_i;
        wp_q        <= ~wp_q;
      end
      if (pop_i) rp_q <= ~rp_q;
      cnt_q <= cnt_q + (push_i ? 2'd1 : 2'd0) - (pop_i ? 2'd1 : 2'd0);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q < 2'd2 || pop_i));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (cnt_q != 2'd0));
endmodule

// File: rtl/sgc_dma.sv
module sgc_dma
  import sgc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 128,
  parameter int LW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-4:0]   src_base_i,
  input  logic [AW-4:0]   dst_base_i,
  input  logic [AW-1:0]   size_i,
  input  logic [2*LW-1:0] src_geom_i,
  input  logic [2*LW-1:0] dst_geom_i,
  input  logic            start_i,
  output logic [31:0]     ctrl_o,
  output logic            irq_o,
  output logic            rd_req_o,
  output logic [AW-1:0]   rd_addr_o,
  input  logic            rd_gnt_i,
  input  logic            rd_valid_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic            wr_req_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [DW-1:0]   wr_data_o,
  input  logic            wr_gnt_i
);
  localparam int CW = AW - CHUNK_SHIFT;

  logic          busy_q, done_q, err_q;
  logic [CW-1:0] rd_left_q, wr_left_q;
  logic [1:0]    inflight_q, buf_cnt;
  logic          buf_empty;
  logic [2:0]    occ;
  logic          src_eol, dst_eol;

  // named events for assertions
  logic start_req, cfg_bad, start_ok, start_bad, rd_fire, wr_fire, last_write, finish_evt;

  function automatic logic bad_cfg(input logic [AW-1:0] sz, input logic [LW-1:0] ws,
                                   input logic [LW-1:0] wd);
    return (sz == '0) || (sz[CHUNK_SHIFT-1:0] != '0) || (ws == '0) || (wd == '0);
  endfunction

  assign start_req  = start_i && !busy_q;
  assign cfg_bad    = bad_cfg(size_i, src_geom_i[LW-1:0], dst_geom_i[LW-1:0]);
  assign start_ok   = start_req && !cfg_bad;
  assign start_bad  = start_req && cfg_bad;
  assign occ        = {1'b0, inflight_q} + {1'b0, buf_cnt};
  assign rd_req_o   = busy_q && (rd_left_q != '0) && (occ < 3'(BUF_DEPTH));
  assign wr_req_o   = busy_q && !buf_empty;
  assign rd_fire    = rd_req_o && rd_gnt_i;
  assign wr_fire    = wr_req_o && wr_gnt_i;
  assign last_write = wr_fire && (wr_left_q == CW'(1));
  assign finish_evt = last_write || start_bad;

  sgc_walk #(.AW(AW), .LW(LW), .CS(CHUNK_SHIFT)) u_src_walk (
    .clk(clk), .rst_n(rst_n), .load_i(start_ok), .active_i(busy_q),
    .base_i({src_base_i, 3'b000}), .width_i(src_geom_i[LW-1:0]),
    .gap_i(src_geom_i[2*LW-1:LW]), .step_i(rd_fire),
    .addr_o(rd_addr_o), .eol_o(src_eol));

  sgc_walk #(.AW(AW), .LW(LW), .CS(CHUNK_SHIFT)) u_dst_walk (
    .clk(clk), .rst_n(rst_n), .load_i(start_ok), .active_i(busy_q),
    .base_i({dst_base_i, 3'b000}), .width_i(dst_geom_i[LW-1:0]),
    .gap_i(dst_geom_i[2*LW-1:LW]), .step_i(wr_fire),
    .addr_o(wr_addr_o), .eol_o(dst_eol));

  sgc_buf2 #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .push_i(rd_valid_i), .din_i(rd_data_i),
    .pop_i(wr_fire), .dout_o(wr_data_o), .empty_o(buf_empty), .count_o(buf_cnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      irq_o      <= 1'b0;
      rd_left_q  <= '0;
      wr_left_q  <= '0;
      inflight_q <= 2'd0;
    end else begin
      irq_o      <= finish_evt;
      inflight_q <= inflight_q + (rd_fire ? 2'd1 : 2'd0) - (rd_valid_i ? 2'd1 : 2'd0);
      if (start_req) begin
        busy_q <= start_ok;
        done_q <= start_bad;
        err_q  <= start_bad;
      end else if (last_write) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
      if (start_ok) begin
        rd_left_q <= size_i[AW-1:CHUNK_SHIFT];
        wr_left_q <= size_i[AW-1:CHUNK_SHIFT];
      end else begin
        if (rd_fire) rd_left_q <= rd_left_q - CW'(1);
        if (wr_fire) wr_left_q <= wr_left_q - CW'(1);
      end
    end
  end

  always_comb begin
    sgc_status_t st;
    st.busy = busy_q;
    st.done = done_q;
    st.err  = err_q;
    ctrl_o  = pack_ctrl(st);
  end

  assert_occ_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 3'(BUF_DEPTH));
  assert_irq_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctrl_o[CTRL_DONE]);
  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !busy_q);
  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!busy_q && done_q));
  assert_no_extra_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (wr_left_q != '0));
  assert_no_extra_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> (rd_left_q != '0));
  assert_ignore_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !last_write) |=> busy_q);
endmodule

// File: tb/tb_sgc_dma.sv
module tb_sgc_dma;
  localparam int AW = 32;
  localparam int DW = 128;
  localparam int LW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-4:0]   src_base_i = '0, dst_base_i = '0;
  logic [AW-1:0]   size_i = '0;
  logic [2*LW-1:0] src_geom_i = '0, dst_geom_i = '0;
  logic            start_i = 1'b0;
  logic [31:0]     ctrl_o;
  logic            irq_o, rd_req_o, rd_gnt_i = 1'b0, rd_valid_i = 1'b0;
  logic [AW-1:0]   rd_addr_o, wr_addr_o;
  logic [DW-1:0]   rd_data_i = '0, wr_data_o;
  logic            wr_req_o, wr_gnt_i = 1'b0;

  sgc_dma #(.AW(AW), .DW(DW), .LW(LW)) dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cfg_src, cfg_dst, cfg_ws, cfg_gs, cfg_wd, cfg_gd;
  int rd_pct = 100, wr_pct = 100, ret_pct = 100;
  int rd_seen = 0, wr_seen = 0, irq_cnt = 0, max_out = 0;
  logic [31:0] pend[$];

  function automatic int exp_addr(int base, int w, int g, int k);
    return base + 16 * ((k / w) * (w + g) + (k % w));
  endfunction

  function automatic logic [127:0] pat(logic [31:0] a);
    return {a ^ 32'hdeadbeef, ~a, a + 32'h01010101, {a[15:0], a[31:16]}};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // memory model and checker of the two ports
  initial begin
    forever begin
      @(negedge clk);
      rd_valid_i = 1'b0;
      if (pend.size() > 0 && int'($urandom % 100) < ret_pct) begin
        rd_valid_i = 1'b1;
        rd_data_i  = pat(pend.pop_front());
      end
      rd_gnt_i = 1'b0;
      if (rd_req_o && int'($urandom % 100) < rd_pct) begin
        rd_gnt_i = 1'b1;
        chk(rd_addr_o == 32'(exp_addr(cfg_src, cfg_ws, cfg_gs, rd_seen)),
            rd_seen == 0 ? "R1 first read addr" : "R2 read addr",
            rd_addr_o, 32'(exp_addr(cfg_src, cfg_ws, cfg_gs, rd_seen)));
        pend.push_back(rd_addr_o);
        rd_seen++;
      end
      wr_gnt_i = 1'b0;
      if (wr_req_o && int'($urandom % 100) < wr_pct) begin
        wr_gnt_i = 1'b1;
        chk(wr_addr_o == 32'(exp_addr(cfg_dst, cfg_wd, cfg_gd, wr_seen)),
            wr_seen == 0 ? "R1 first write addr" : "R3 write addr",
            wr_addr_o, 32'(exp_addr(cfg_dst, cfg_wd, cfg_gd, wr_seen)));
        chk(wr_data_o == pat(32'(exp_addr(cfg_src, cfg_ws, cfg_gs, wr_seen))), "R4 write data",
            wr_data_o, pat(32'(exp_addr(cfg_src, cfg_ws, cfg_gs, wr_seen))));
        wr_seen++;
      end
      if (rd_seen - wr_seen > max_out) max_out = rd_seen - wr_seen;
      if (irq_o) irq_cnt++;
    end
  end

  task automatic run_copy(input int sb, input int db, input int ws, input int gs,
                          input int wd, input int gd, input int size,
                          input bit stall, input bit restart);
    int n;
    bit bad;
    n   = size / 16;
    bad = (ws == 0) || (wd == 0) || (size == 0) || (size % 16 != 0);
    cfg_src = sb; cfg_dst = db; cfg_ws = ws; cfg_gs = gs; cfg_wd = wd; cfg_gd = gd;
    rd_seen = 0; wr_seen = 0; irq_cnt = 0; max_out = 0;
    @(negedge clk);
    src_base_i = 29'(sb >> 3);
    dst_base_i = 29'(db >> 3);
    size_i     = 32'(size);
    src_geom_i = {16'(gs), 16'(ws)};
    dst_geom_i = {16'(gd), 16'(wd)};
    if (stall) wr_pct = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (bad) begin
      chk(ctrl_o == 32'h300, "R7 error status", ctrl_o, 32'h300);
      chk(irq_o == 1'b1, "R6 irq on error", irq_o, 1);
      @(negedge clk);
      chk(irq_o == 1'b0, "R6 irq one cycle", irq_o, 0);
      repeat (3) @(negedge clk);
      chk(rd_seen == 0 && wr_seen == 0, "R7 no traffic", rd_seen + wr_seen, 0);
      chk(irq_cnt == 1, "R6 single irq", irq_cnt, 1);
      return;
    end
    chk(ctrl_o == 32'h1, "R5 busy after start", ctrl_o, 32'h1);
    if (restart) begin
      size_i     = 32'h100;
      src_geom_i = {16'd7, 16'd1};
      start_i    = 1'b1;
      @(negedge clk);
      start_i    = 1'b0;
    end
    if (stall) begin
      repeat (30) @(negedge clk);
      chk(rd_seen <= 2 && wr_seen == 0, "R8 reads stop under write stall", rd_seen, 2);
      wr_pct = 100;
    end
    for (int i = 0; i < 3000 && !ctrl_o[8]; i++) @(negedge clk);
    chk(ctrl_o[8] == 1'b1, "R5 done reached", ctrl_o, 32'h100);
    chk(irq_o == 1'b1, "R6 irq with done", irq_o, 1);
    repeat (3) @(negedge clk);
    chk(ctrl_o == 32'h100, "R5 final status", ctrl_o, 32'h100);
    chk(rd_seen == n, restart ? "R9 read count" : "R4 read count", rd_seen, n);
    chk(wr_seen == n, restart ? "R9 write count" : "R4 write count", wr_seen, n);
    chk(irq_cnt == 1, "R6 single irq", irq_cnt, 1);
    chk(max_out <= 2, "R8 outstanding", max_out, 2);
  endtask

  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ctrl_o == 32'h0, "R10 ctrl after reset", ctrl_o, 0);
    chk(irq_o == 1'b0 && rd_req_o == 1'b0 && wr_req_o == 1'b0, "R10 quiet after reset",
        {irq_o, rd_req_o, wr_req_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ctrl_o == 32'h0 && !rd_req_o && !wr_req_o, "R10 idle", ctrl_o, 0);

    // directed corners
    run_copy(32'h1000, 32'h8000, 3, 2, 2, 5, 16 * 7, 1'b0, 1'b0);
    run_copy(32'h0008, 32'h4008, 1, 0, 1, 0, 16, 1'b0, 1'b0);
    run_copy(32'h2000, 32'h6000, 4, 1, 3, 0, 16 * 12, 1'b1, 1'b0);
    run_copy(32'h3000, 32'h7000, 2, 3, 5, 1, 16 * 9, 1'b0, 1'b1);
    run_copy(32'h1000, 32'h2000, 0, 1, 2, 0, 64, 1'b0, 1'b0);   // R7 zero src width
    run_copy(32'h1000, 32'h2000, 2, 1, 0, 0, 64, 1'b0, 1'b0);   // R7 zero dst width
    run_copy(32'h1000, 32'h2000, 2, 1, 2, 0, 0, 1'b0, 1'b0);    // R7 zero size
    run_copy(32'h1000, 32'h2000, 2, 1, 2, 0, 40, 1'b0, 1'b0);   // R7 unaligned size

    // constrained random
    for (int r = 0; r < 30; r++) begin
      rd_pct  = 40 + int'($urandom % 61);
      wr_pct  = 40 + int'($urandom % 61);
      ret_pct = 40 + int'($urandom % 61);
      run_copy(int'($urandom % 4096) * 8, int'($urandom % 4096) * 8 + 32'h10000,
               1 + int'($urandom % 4), int'($urandom % 4),
               1 + int'($urandom % 4), int'($urandom % 4),
               16 * (1 + int'($urandom % 24)), 1'b0, 1'b0);
    end
    rd_pct = 100; wr_pct = 100; ret_pct = 100;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule